// File: doc/BRIEF.md
# Overcurrent Off-Time Timer and Fault Reporter

This block sits between per-channel overcurrent comparators and the gate-drive logic of a two-channel power stage. Channels are called A and B. The stage runs either as one full bridge or as two independent half bridges. When a channel's overcurrent pulse is sampled high, that channel starts a fixed off-time. The off-time is counted in clock cycles. While it runs, the channel's inhibit output holds its drive off.

Two active-low status outputs report faults. Their meaning depends on the mode:
- **Full-bridge mode:** one output is the bridge-wide fault flag, raised by undervoltage or by either channel's off-time. The other flags current limit only, raised by either off-time.
- **Half-bridge mode:** each output reports undervoltage or the off-time of its own channel.

No status is latched. Each output returns high as soon as its cause has gone.

Top module: `ocp_fault_reporter`

## Requirements
- R1: When `ocA` is high at a rising clock edge, `inhibitA` is high from that edge on for exactly N cycles, where N is the value of `offTime` at that edge.
- R2: The two channels are independent. A pulse on one channel never changes the other channel's inhibit output or off-time count.
- R3: A pulse that arrives while a channel's off-time is running restarts that channel's count from the full off-time.
- R4: `offTime` is sampled only at the trigger edge. Changing it while an off-time runs does not change that run's length.
- R5: An `offTime` of 0 gives an off-time of exactly one cycle.
- R6: In full-bridge mode (`fullMode`=1), `clFaultBN` is low exactly while either channel's inhibit is high. Undervoltage does not affect it.
- R7: In full-bridge mode, `faultAN` is low exactly while `underVolt` was high at the last edge or either inhibit is high.
- R8: In half-bridge mode (`fullMode`=0):
  - `faultAN` is low exactly while `underVolt` was high at the last edge or `inhibitA` is high.
  - `clFaultBN` is low exactly while `underVolt` was high at the last edge or `inhibitB` is high.
- R9: Fault outputs are not latched. They return high in the cycle after their cause clears, with no clear input.
- R10: While `rstN` is low, both inhibits are low and both fault outputs are high. Every output is registered, so a change on an input shows up after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fullMode | input | 1 | 1 = full bridge, 0 = two half bridges |
| ocA | input | 1 | Overcurrent pulse, channel A |
| ocB | input | 1 | Overcurrent pulse, channel B |
| underVolt | input | 1 | Undervoltage flag, active high |
| offTime | input | CNT_W | Off-time length in cycles (0 means 1) |
| inhibitA | output | 1 | Channel A drive inhibit, active high |
| inhibitB | output | 1 | Channel B drive inhibit, active high |
| faultAN | output | 1 | Bridge fault (full) or channel A fault (half), active low |
| clFaultBN | output | 1 | Current limit (full) or channel B fault (half), active low |

## Verification
Single isolated pulses with off-times from 0 upward separate a correct off-time length from off-by-one and missing-clamp errors. A second pulse mid-run shows whether the count restarts. A change of `offTime` mid-run shows whether the length was sampled at the trigger. A long pseudo-random sweep of pulses on both channels and undervoltage, in both modes, is compared cycle by cycle against an arithmetic model. It tells apart the mode-dependent routing of each fault output and the cross-channel isolation in half-bridge mode.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

  localparam int NUM_CH = 2;

  // Strobes handed from the trigger control to the timer datapath.
  typedef struct packed {
    logic [NUM_CH-1:0] load;
    logic              fullMode;
    logic              underVolt;
  } ocpStrobe_t;

endpackage

// File: rtl/ocp_trig_ctrl.sv
module ocp_trig_ctrl
  import ocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             fullMode,
  input  logic             ocA,
  input  logic             ocB,
  input  logic             underVolt,
  input  logic [CNT_W-1:0] offTime,
  output ocpStrobe_t       strobes,
  output logic [CNT_W-1:0] loadVal
);

  localparam logic [CNT_W-1:0] MIN_OFF = CNT_W'(1);

  always_comb begin
    strobes.load[0]   = ocA;
    strobes.load[1]   = ocB;
    strobes.fullMode  = fullMode;
    strobes.underVolt = underVolt;
  end

  // A programmed zero would give no inhibit at all; treat it as one cycle.
  always_comb begin
    if (offTime == '0) loadVal = MIN_OFF;
    else               loadVal = offTime;
  end

endmodule

// File: rtl/ocp_timer_path.sv
module ocp_timer_path
  import ocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ocpStrobe_t        strobes,
  input  logic [CNT_W-1:0]  loadVal,
  output logic [NUM_CH-1:0] inhibit,
  output logic              faultAN,
  output logic              clFaultBN
);

  logic [NUM_CH-1:0][CNT_W-1:0] cnt;
  logic [NUM_CH-1:0][CNT_W-1:0] cntNext;
  logic [NUM_CH-1:0]            busyNext;

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
    always_comb begin
      if (strobes.load[ch])  cntNext[ch] = loadVal;
      else if (cnt[ch] != '0) cntNext[ch] = cnt[ch] - CNT_W'(1);
      else                    cntNext[ch] = '0;
      busyNext[ch] = (cntNext[ch] != '0);
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt[ch]     <= '0;
        inhibit[ch] <= 1'b0;
      end else begin
        cnt[ch]     <= cntNext[ch];
        inhibit[ch] <= busyNext[ch];
      end
    end

    // A trigger always lands the full sampled off-time in the counter.
    assert_restart_full_R3: assert property (@(posedge clk) disable iff (!rstN)
      strobes.load[ch] |=> (cnt[ch] == $past(loadVal) && inhibit[ch]));

    // An idle counter never wraps.
    assert_no_underflow_R1: assert property (@(posedge clk) disable iff (!rstN)
      (cnt[ch] == '0 && !strobes.load[ch]) |=> (cnt[ch] == '0 && !inhibit[ch]));
  end

  logic faNext;
  logic fbNext;

  always_comb begin
    if (strobes.fullMode) begin
      faNext = !(strobes.underVolt || busyNext[0] || busyNext[1]);
      fbNext = !(busyNext[0] || busyNext[1]);
    end else begin
      faNext = !(strobes.underVolt || busyNext[0]);
      fbNext = !(strobes.underVolt || busyNext[1]);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultAN   <= 1'b1;
      clFaultBN <= 1'b1;
    end else begin
      faultAN   <= faNext;
      clFaultBN <= fbNext;
    end
  end

  assert_uv_flags_a_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.underVolt |=> !faultAN);

  assert_cl_ignores_uv_R6: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.fullMode && cnt == '0 && strobes.load == '0) |=> clFaultBN);

  assert_auto_clear_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.underVolt && cnt == '0 && strobes.load == '0) |=> (faultAN && clFaultBN));

  assert_half_isolated_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.fullMode && !strobes.underVolt && cnt[1] == '0 && !strobes.load[1]) |=> clFaultBN);

endmodule

// File: rtl/ocp_fault_reporter.sv
module ocp_fault_reporter
  import ocp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fullMode,
  input  logic             ocA,
  input  logic             ocB,
  input  logic             underVolt,
  input  logic [CNT_W-1:0] offTime,
  output logic             inhibitA,
  output logic             inhibitB,
  output logic             faultAN,
  output logic             clFaultBN
);

  ocpStrobe_t        strobes;
  logic [CNT_W-1:0]  loadVal;
  logic [NUM_CH-1:0] inhibit;

  ocp_trig_ctrl #(.CNT_W(CNT_W)) i_ctrl (
    .fullMode  (fullMode),
    .ocA       (ocA),
    .ocB       (ocB),
    .underVolt (underVolt),
    .offTime   (offTime),
    .strobes   (strobes),
    .loadVal   (loadVal)
  );

  ocp_timer_path #(.CNT_W(CNT_W)) i_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .loadVal   (loadVal),
    .inhibit   (inhibit),
    .faultAN   (faultAN),
    .clFaultBN (clFaultBN)
  );

  assign inhibitA = inhibit[0];
  assign inhibitB = inhibit[1];

  assert_reset_state_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (faultAN && clFaultBN && !inhibitA && !inhibitB));

endmodule

// File: tb/test_ocp_fault_reporter.sv
module test_ocp_fault_reporter;

  localparam int CLK_PERIOD = 10;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic fullMode = 1'b1;
  logic ocA = 1'b0;
  logic ocB = 1'b0;
  logic underVolt = 1'b0;
  logic [CNT_W-1:0] offTime = '0;
  logic inhibitA, inhibitB, faultAN, clFaultBN;

  int checks = 0;
  int fails = 0;
  int remA = 0;
  int remB = 0;
  bit expIA = 0, expIB = 0, expFA = 1, expFB = 1;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ocp_fault_reporter #(.CNT_W(CNT_W)) i_ocp_fault_reporter (
    .clk(clk), .rstN(rstN), .fullMode(fullMode), .ocA(ocA), .ocB(ocB),
    .underVolt(underVolt), .offTime(offTime), .inhibitA(inhibitA),
    .inhibitB(inhibitB), .faultAN(faultAN), .clFaultBN(clFaultBN)
  );

  task automatic check(input bit act, input bit exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
    end
  endtask

  // Reference model of one rising edge, built from the requirements.
  task automatic modelEdge();
    int ld;
    ld = (offTime == 0) ? 1 : int'(offTime);
    if (ocA) remA = ld; else if (remA > 0) remA--;
    if (ocB) remB = ld; else if (remB > 0) remB--;
    expIA = remA > 0;
    expIB = remB > 0;
    if (fullMode) begin
      expFA = !(underVolt || expIA || expIB);
      expFB = !(expIA || expIB);
    end else begin
      expFA = !(underVolt || expIA);
      expFB = !(underVolt || expIB);
    end
  endtask

  task automatic compareAll();
    check(inhibitA, expIA, "R1", "inhibitA");
    check(inhibitB, expIB, "R2", "inhibitB");
    check(faultAN, expFA, fullMode ? "R7" : "R8", "faultAN");
    check(clFaultBN, expFB, fullMode ? "R6" : "R8", "clFaultBN");
  endtask

  task automatic cycle();
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    compareAll();
  endtask

  // Pulse channel A once, then count the cycles inhibitA stays high.
  task automatic pulseA(output int len);
    ocA = 1'b1;
    cycle();
    ocA = 1'b0;
    len = 0;
    while (inhibitA && len < 300) begin
      len++;
      cycle();
    end
  endtask

  initial begin
    int len;
    bit bOk;
    logic [15:0] lfsr;
    repeat (3) @(negedge clk);
    // R10: reset state
    check(inhibitA, 1'b0, "R10", "reset inhibitA");
    check(inhibitB, 1'b0, "R10", "reset inhibitB");
    check(faultAN, 1'b1, "R10", "reset faultAN");
    check(clFaultBN, 1'b1, "R10", "reset clFaultBN");
    rstN = 1'b1;
    cycle();

    // R1: length equals offTime
    for (int n = 1; n <= 6; n++) begin
      offTime = CNT_W'(n);
      pulseA(len);
      check(len == n, 1'b1, "R1", $sformatf("off-time length for %0d", n));
      cycle();
    end

    // R5: zero means one cycle
    offTime = '0;
    pulseA(len);
    check(len == 1, 1'b1, "R5", "zero off-time length");

    // R4: change mid-run ignored
    offTime = 8'd6;
    ocA = 1'b1; cycle(); ocA = 1'b0;
    offTime = 8'd1;
    len = 1;
    cycle();
    while (inhibitA && len < 300) begin len++; cycle(); end
    check(len == 6, 1'b1, "R4", "length after mid-run offTime change");

    // R3: retrigger restarts: 3 cycles then full 5
    offTime = 8'd5;
    ocA = 1'b1; cycle(); ocA = 1'b0;
    cycle(); cycle();
    pulseA(len);
    check(len == 5, 1'b1, "R3", "length after retrigger");

    // R2/R8: half mode, A pulse leaves B side alone
    fullMode = 1'b0;
    offTime = 8'd4;
    cycle();
    ocA = 1'b1; cycle(); ocA = 1'b0;
    bOk = 1;
    for (int k = 0; k < 5; k++) begin
      if (inhibitB !== 1'b0 || clFaultBN !== 1'b1) bOk = 0;
      cycle();
    end
    check(bOk, 1'b1, "R2", "channel B untouched by A in half mode");

    // R9: uv then release, faults come back without clear
    underVolt = 1'b1; cycle();
    check(faultAN, 1'b0, "R8", "half-mode uv on faultAN");
    check(clFaultBN, 1'b0, "R8", "half-mode uv on clFaultBN");
    underVolt = 1'b0; cycle();
    check(faultAN & clFaultBN, 1'b1, "R9", "auto clear after uv");

    // R6: full mode uv does not touch current-limit output
    fullMode = 1'b1; underVolt = 1'b1; cycle();
    check(clFaultBN, 1'b1, "R6", "uv ignored by current-limit output");
    check(faultAN, 1'b0, "R7", "uv on bridge fault");
    underVolt = 1'b0; cycle();

    // Sweep both modes, several off-times, pseudo-random stimulus
    lfsr = 16'hACE1;
    for (int m = 0; m < 2; m++) begin
      for (int n = 0; n < 8; n++) begin
        fullMode = m[0];
        offTime = CNT_W'(n);
        for (int c = 0; c < 60; c++) begin
          lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
          ocA = (lfsr[3:0] == 4'h0);
          ocB = (lfsr[7:4] == 4'h1);
          underVolt = (lfsr[11:8] < 4'h2);
          cycle();
        end
        ocA = 0; ocB = 0; underVolt = 0;
        repeat (10) cycle();
      end
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule